// File: doc/BRIEF.md
# Indirect Interrupt Register Access Gate

This block sits in front of the CSR file of a hart that has the hypervisor extension and indirect interrupt-register windows. It holds the three interrupt-select registers: the machine select, the supervisor select and the guest-supervisor select. It also keeps local copies of two control bits. One is the supervisor external-interrupt virtualization enable. The other is the guest trap-on-interrupt-register-access bit.

For every CSR access strobe, the block looks at the 12-bit CSR address, the current privilege (M, S or U) and the virtualization flag. It returns one of three verdicts in the same cycle: allowed, illegal-instruction or virtual-instruction. The verdict depends on the access itself and on the value currently held in the relevant select register.

The gate is meant to run ahead of the CSR file's generic legality check. The pipeline raises the reported exception kind. A verdict of allowed hands the access on to the later checks.

A write that the gate allows updates a select register or a control copy on the next clock edge. Writes to the three top-interrupt registers are allowed and have no effect. Their read value here is zero. Addresses and modes that no rule below covers are always allowed.

Top module: `isel_access_gate`

## Requirements
- R1: After reset all three select registers and both control copies are zero, so reads of 0x350, 0x150, 0x250, 0x308 and 0x609 return 0.
- R2: An allowed write to 0x350, 0x150 or 0x250 stores the low SEL_W (default 12) data bits at the next clock edge. A write to 0x308 stores data bit 9 as the external-virtualization enable. A write to 0x609 stores data bit 30 as the trap bit. Each value reads back at the same address and bit position.
- R3: In M mode, an access to 0x351 is illegal when the machine select is at most 0x2F, lies in 0x40..0x6F, exceeds 0xFF, or is odd.
- R4: An access to 0x15C from non-virtualized S mode is illegal while the external-virtualization enable is 1.
- R5: An access to 0x151 from non-virtualized S mode with the external-virtualization enable set is illegal when the supervisor select is in 0x70..0xFF. This includes even values that the range rule of R6 would allow.
- R6: An access to 0x151 from M mode or non-virtualized S mode is illegal when the supervisor select is at most 0x2F, lies in 0x40..0x6F, exceeds 0xFF, or is odd.
- R7: An access to 0x151 from virtualized S mode is decided by the guest select. A value above 0x1FF is illegal. Otherwise a value in 0x30..0x3F, or an odd value in 0x81..0xFF, gives a virtual-instruction verdict. Any other value is allowed.
- R8: Any access to 0x151 from virtualized U mode gives a virtual-instruction verdict.
- R9: An access to 0x251 from M mode or non-virtualized S mode is illegal when the guest select is at most 0x6F, exceeds 0xFF, or is odd. Any access to 0x251 while virtualized (S or U) gives a virtual-instruction verdict.
- R10: An access to 0x144 or 0x104 from virtualized S mode gives a virtual-instruction verdict while the trap bit is 1, and is allowed while it is 0.
- R11: Writes to 0xFB0, 0xDB0 and 0xEB0 are allowed and change no state. Reads of these addresses return 0.
- R12: The verdict is combinational and valid in the cycle of the strobe. It is encoded 0 = allowed, 1 = illegal-instruction, 2 = virtual-instruction, and it is 0 whenever the strobe is low.
- R13: Accesses to any other address, or from modes that no rule above names, are allowed. The virtualization flag is ignored in M mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | CSR access strobe |
| acc_addr | input | 12 | CSR address |
| acc_wr | input | 1 | Access writes the CSR |
| acc_wdata | input | XLEN | Write data |
| cur_priv | input | 2 | Current privilege: 3 = M, 1 = S, 0 = U |
| cur_virt | input | 1 | Virtualization flag |
| verdict | output | 2 | 0 allowed, 1 illegal-instruction, 2 virtual-instruction |
| rdata | output | XLEN | Read value of the addressed select register or control copy, else 0 |

## Verification
A wrong select or control value is invisible until the next access that depends on it. It then shows up as a wrong verdict kind in that same cycle, and as a wrong read value at the owning address. A select register that loses bits above bit 7 shows up only through the "exceeds 0xFF" and "above 0x1FF" windows. For that reason the stimulus drives select values up to 12 bits wide. Each verdict is compared against a bench model in the cycle of the strobe, and each write is confirmed by reading the same address back one cycle later.

// File: rtl/isel_pkg.sv
package isel_pkg;

   typedef enum logic [1:0] {
      VERD_OK   = 2'd0,
      VERD_ILL  = 2'd1,
      VERD_VIRT = 2'd2
   } verdict_e;

   localparam logic [1:0] PRIV_U = 2'd0;
   localparam logic [1:0] PRIV_S = 2'd1;
   localparam logic [1:0] PRIV_M = 2'd3;

   localparam logic [11:0] A_MSEL   = 12'h350;
   localparam logic [11:0] A_MWIN   = 12'h351;
   localparam logic [11:0] A_SSEL   = 12'h150;
   localparam logic [11:0] A_SWIN   = 12'h151;
   localparam logic [11:0] A_SEXTOP = 12'h15C;
   localparam logic [11:0] A_VSSEL  = 12'h250;
   localparam logic [11:0] A_VSWIN  = 12'h251;
   localparam logic [11:0] A_MVEN   = 12'h308;
   localparam logic [11:0] A_HVCTL  = 12'h609;
   localparam logic [11:0] A_SIP    = 12'h144;
   localparam logic [11:0] A_SIE    = 12'h104;
   localparam logic [11:0] A_MTOP   = 12'hFB0;
   localparam logic [11:0] A_STOP   = 12'hDB0;
   localparam logic [11:0] A_VSTOP  = 12'hEB0;

   localparam int SEIE_BIT = 9;
   localparam int VTI_BIT  = 30;

   // host-side window rule shared by machine and supervisor windows
   function automatic logic host_win_bad(input logic [11:0] s);
      return (s <= 12'h02F) || (s >= 12'h040 && s <= 12'h06F) ||
             (s > 12'h0FF) || s[0];
   endfunction

   // host-side access to the guest window
   function automatic logic guest_host_bad(input logic [11:0] s);
      return (s <= 12'h06F) || (s > 12'h0FF) || s[0];
   endfunction

   // guest-side selects that trap to the hypervisor
   function automatic logic guest_trap_win(input logic [11:0] s);
      return (s >= 12'h030 && s <= 12'h03F) ||
             (s >= 12'h081 && s <= 12'h0FF && s[0]);
   endfunction

endpackage

// File: rtl/isel_regs.sv
module isel_regs
   import isel_pkg::*;
#(
   parameter int SEL_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [11:0]      wr_addr,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic             wr_seie,
   input  logic             wr_vti,
   output logic [SEL_W-1:0] m_sel,
   output logic [SEL_W-1:0] s_sel,
   output logic [SEL_W-1:0] vs_sel,
   output logic             seie,
   output logic             vti
);
   localparam int NSEL = 3;
   localparam logic [11:0] SEL_ADDR [NSEL] = '{A_MSEL, A_SSEL, A_VSSEL};

   logic [SEL_W-1:0] sel_q [NSEL];

   for (genvar i = 0; i < NSEL; i++) begin : g_sel
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sel_q[i] <= '0;
         else if (wr_en && wr_addr == SEL_ADDR[i])
            sel_q[i] <= wr_sel;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seie <= 1'b0;
         vti  <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == A_MVEN)  seie <= wr_seie;
         if (wr_addr == A_HVCTL) vti  <= wr_vti;
      end
   end

   assign m_sel  = sel_q[0];
   assign s_sel  = sel_q[1];
   assign vs_sel = sel_q[2];

   assert_sel_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr == A_SSEL |=> s_sel == $past(wr_sel));

   assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(seie) && $stable(vti) && $stable(m_sel));
endmodule

// File: rtl/isel_verdict.sv
module isel_verdict
   import isel_pkg::*;
#(
   parameter int SEL_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld,
   input  logic [11:0]      addr,
   input  logic [1:0]       priv,
   input  logic             virt,
   input  logic [SEL_W-1:0] m_sel,
   input  logic [SEL_W-1:0] s_sel,
   input  logic [SEL_W-1:0] vs_sel,
   input  logic             seie,
   input  logic             vti,
   output verdict_e         verdict
);
   logic [11:0] m12, s12, vs12;
   logic is_m, s_host, s_guest, u_guest, guest;

   assign m12  = 12'(m_sel);
   assign s12  = 12'(s_sel);
   assign vs12 = 12'(vs_sel);

   assign is_m    = (priv == PRIV_M);
   assign guest   = virt && !is_m;
   assign s_host  = !virt && priv == PRIV_S;
   assign s_guest = guest && priv == PRIV_S;
   assign u_guest = guest && priv == PRIV_U;

   // fixed order: ext-top, machine window, supervisor window, guest window, sip/sie
   always_comb begin
      verdict = VERD_OK;
      if (vld) begin
         if (addr == A_SEXTOP) begin
            if (s_host && seie) verdict = VERD_ILL;
         end else if (addr == A_MWIN) begin
            if (is_m && host_win_bad(m12)) verdict = VERD_ILL;
         end else if (addr == A_SWIN) begin
            if (s_host && seie && s12 >= 12'h070 && s12 <= 12'h0FF)
               verdict = VERD_ILL;
            else if ((is_m || s_host) && host_win_bad(s12))
               verdict = VERD_ILL;
            else if (s_guest) begin
               if (vs12 > 12'h1FF)            verdict = VERD_ILL;
               else if (guest_trap_win(vs12)) verdict = VERD_VIRT;
            end else if (u_guest)
               verdict = VERD_VIRT;
         end else if (addr == A_VSWIN) begin
            if ((is_m || s_host) && guest_host_bad(vs12)) verdict = VERD_ILL;
            else if (guest)                              verdict = VERD_VIRT;
         end else if (addr == A_SIP || addr == A_SIE) begin
            if (s_guest && vti) verdict = VERD_VIRT;
         end
      end
   end

   // R7/R8/R9/R10: a virtual-instruction verdict only ever arises while virtualized below M
   assert_virt_needs_guest_R7: assert property (@(posedge clk) disable iff (!rst_n)
      verdict == VERD_VIRT |-> virt && priv != PRIV_M);

   assert_mwin_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      vld && addr == A_MWIN && priv == PRIV_M && m_sel[0] |-> verdict == VERD_ILL);

   assert_guest_vswin_R9: assert property (@(posedge clk) disable iff (!rst_n)
      vld && addr == A_VSWIN && virt && priv != PRIV_M |-> verdict == VERD_VIRT);
endmodule

// File: rtl/isel_access_gate.sv
module isel_access_gate
   import isel_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int SEL_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_vld,
   input  logic [11:0]     acc_addr,
   input  logic            acc_wr,
   input  logic [XLEN-1:0] acc_wdata,
   input  logic [1:0]      cur_priv,
   input  logic            cur_virt,
   output logic [1:0]      verdict,
   output logic [XLEN-1:0] rdata
);
   if (SEL_W < 10 || SEL_W > 12) begin : g_bad_selw
      $error("SEL_W must be 10..12 to hold every decoded window");
   end
   if (XLEN < 32) begin : g_bad_xlen
      $error("XLEN must hold the trap bit at position 30");
   end

   logic [SEL_W-1:0] m_sel, s_sel, vs_sel;
   logic             seie, vti, wr_en;
   verdict_e         verd;

   assign wr_en = acc_vld && acc_wr && verd == VERD_OK;

   logic unused_wdata;
   assign unused_wdata = ^acc_wdata;

   isel_regs #(.SEL_W(SEL_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (acc_addr),
      .wr_sel  (acc_wdata[SEL_W-1:0]),
      .wr_seie (acc_wdata[SEIE_BIT]),
      .wr_vti  (acc_wdata[VTI_BIT]),
      .m_sel   (m_sel),
      .s_sel   (s_sel),
      .vs_sel  (vs_sel),
      .seie    (seie),
      .vti     (vti)
   );

   isel_verdict #(.SEL_W(SEL_W)) u_verdict (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (acc_vld),
      .addr    (acc_addr),
      .priv    (cur_priv),
      .virt    (cur_virt),
      .m_sel   (m_sel),
      .s_sel   (s_sel),
      .vs_sel  (vs_sel),
      .seie    (seie),
      .vti     (vti),
      .verdict (verd)
   );

   assign verdict = verd;

   always_comb begin
      rdata = '0;
      unique case (acc_addr)
         A_MSEL:  rdata = XLEN'(m_sel);
         A_SSEL:  rdata = XLEN'(s_sel);
         A_VSSEL: rdata = XLEN'(vs_sel);
         A_MVEN:  rdata[SEIE_BIT] = seie;
         A_HVCTL: rdata[VTI_BIT]  = vti;
         default: rdata = '0;
      endcase
   end

   assert_top_wr_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vld && acc_wr && (acc_addr == A_MTOP || acc_addr == A_STOP || acc_addr == A_VSTOP)
      |=> $stable(m_sel) && $stable(s_sel) && $stable(vs_sel) && $stable(seie) && $stable(vti));

   assert_idle_ok_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_vld |-> verdict == 2'd0);

   assert_top_ok_R11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vld && (acc_addr == A_MTOP || acc_addr == A_STOP || acc_addr == A_VSTOP)
      |-> verdict == 2'd0);
endmodule

// File: tb/isel_access_gate_bench.sv
`timescale 1ns/1ps
module isel_access_gate_bench;
   localparam int XLEN = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            acc_vld = 1'b0;
   logic [11:0]     acc_addr = '0;
   logic            acc_wr = 1'b0;
   logic [XLEN-1:0] acc_wdata = '0;
   logic [1:0]      cur_priv = 2'd3;
   logic            cur_virt = 1'b0;
   logic [1:0]      verdict;
   logic [XLEN-1:0] rdata;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   // bench model
   logic [11:0] bm = '0, bs = '0, bvs = '0;
   logic        bseie = 1'b0, bvti = 1'b0;

   always #2.5 clk = ~clk;

   isel_access_gate #(.XLEN(XLEN), .SEL_W(12)) u_isel_access_gate (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_addr(acc_addr),
      .acc_wr(acc_wr), .acc_wdata(acc_wdata), .cur_priv(cur_priv),
      .cur_virt(cur_virt), .verdict(verdict), .rdata(rdata)
   );

   function automatic logic hbad(input logic [11:0] s);
      return s < 12'h30 || (s > 12'h3F && s < 12'h70) || s > 12'hFF || s[0];
   endfunction

   function automatic logic [1:0] exp_verdict(input logic [11:0] a, input logic [1:0] p, input logic v);
      logic m, sh, sg, ug, g;
      m = (p == 2'd3); g = v && !m;
      sh = !v && p == 2'd1; sg = g && p == 2'd1; ug = g && p == 2'd0;
      case (a)
         12'h15C: return (sh && bseie) ? 2'd1 : 2'd0;                     // R4
         12'h351: return (m && hbad(bm)) ? 2'd1 : 2'd0;                   // R3
         12'h151: begin
            if (sh && bseie && bs >= 12'h70 && bs <= 12'hFF) return 2'd1; // R5
            if ((m || sh) && hbad(bs)) return 2'd1;                       // R6
            if (sg) begin                                                 // R7
               if (bvs > 12'h1FF) return 2'd1;
               if ((bvs >= 12'h30 && bvs <= 12'h3F) || (bvs >= 12'h81 && bvs <= 12'hFF && bvs[0]))
                  return 2'd2;
               return 2'd0;
            end
            if (ug) return 2'd2;                                          // R8
            return 2'd0;
         end
         12'h251: begin                                                   // R9
            if ((m || sh) && (bvs < 12'h70 || bvs > 12'hFF || bvs[0])) return 2'd1;
            if (g) return 2'd2;
            return 2'd0;
         end
         12'h144, 12'h104: return (sg && bvti) ? 2'd2 : 2'd0;             // R10
         default: return 2'd0;                                            // R13
      endcase
   endfunction

   function automatic logic [XLEN-1:0] exp_rdata(input logic [11:0] a);
      logic [XLEN-1:0] r;
      r = '0;
      case (a)
         12'h350: r[11:0] = bm;
         12'h150: r[11:0] = bs;
         12'h250: r[11:0] = bvs;
         12'h308: r[9] = bseie;
         12'h609: r[30] = bvti;
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string tag_of(input logic [11:0] a);
      case (a)
         12'h15C: return "R4";
         12'h351: return "R3";
         12'h151: return "R6";
         12'h251: return "R9";
         12'h144, 12'h104: return "R10";
         12'hFB0, 12'hDB0, 12'hEB0: return "R11";
         12'h350, 12'h150, 12'h250, 12'h308, 12'h609: return "R2";
         default: return "R13";
      endcase
   endfunction

   task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // one access; verdict and read value checked mid-cycle, model updated at the edge
   task automatic access(input logic [11:0] a, input logic w, input logic [XLEN-1:0] d,
                         input logic [1:0] p, input logic v, input string tag);
      logic [1:0] ev;
      @(negedge clk);
      acc_vld = 1'b1; acc_addr = a; acc_wr = w; acc_wdata = d; cur_priv = p; cur_virt = v;
      #1;
      ev = exp_verdict(a, p, v);
      check(tag, XLEN'(verdict), XLEN'(ev));
      check(tag, rdata, exp_rdata(a));
      @(posedge clk);
      if (w && ev == 2'd0) begin
         case (a)
            12'h350: bm = d[11:0];
            12'h150: bs = d[11:0];
            12'h250: bvs = d[11:0];
            12'h308: bseie = d[9];
            12'h609: bvti = d[30];
            default: ;
         endcase
      end
      @(negedge clk);
      acc_vld = 1'b0; acc_wr = 1'b0;
   endtask

   task automatic wsel(input logic [11:0] a, input logic [XLEN-1:0] d);
      access(a, 1'b1, d, 2'd3, 1'b0, "R2");
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [11:0] alist [14];
      void'($urandom(32'h5eed));
      alist = '{12'h350, 12'h351, 12'h150, 12'h151, 12'h15C, 12'h250, 12'h251,
                12'h308, 12'h609, 12'h144, 12'h104, 12'hFB0, 12'hDB0, 12'hEB0};
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      access(12'h350, 0, '0, 2'd3, 0, "R1");
      access(12'h150, 0, '0, 2'd3, 0, "R1");
      access(12'h250, 0, '0, 2'd3, 0, "R1");
      access(12'h308, 0, '0, 2'd3, 0, "R1");
      access(12'h609, 0, '0, 2'd3, 0, "R1");

      // R12 no strobe gives allowed even on a failing window
      @(negedge clk);
      acc_addr = 12'h351; cur_priv = 2'd3; acc_vld = 1'b0; #1;
      check("R12", XLEN'(verdict), '0);

      // R3 machine window
      wsel(12'h350, 64'h31); access(12'h351, 0, '0, 2'd3, 0, "R3");
      wsel(12'h350, 64'h30); access(12'h351, 0, '0, 2'd3, 0, "R3");
      wsel(12'h350, 64'h40); access(12'h351, 0, '0, 2'd3, 0, "R3");
      wsel(12'h350, 64'h70); access(12'h351, 0, '0, 2'd3, 0, "R3");
      wsel(12'h350, 64'h100); access(12'h351, 0, '0, 2'd3, 0, "R3");
      access(12'h351, 0, '0, 2'd1, 0, "R13");

      // R4/R5 external virtualization enable
      wsel(12'h308, 64'h200);
      access(12'h15C, 0, '0, 2'd1, 0, "R4");
      access(12'h15C, 0, '0, 2'd1, 1, "R4");
      wsel(12'h150, 64'h70);
      access(12'h151, 0, '0, 2'd1, 0, "R5");
      access(12'h151, 0, '0, 2'd3, 0, "R5");
      wsel(12'h150, 64'h3E);
      access(12'h151, 0, '0, 2'd1, 0, "R6");
      wsel(12'h308, 64'h0);
      wsel(12'h150, 64'h70);
      access(12'h151, 0, '0, 2'd1, 0, "R6");
      wsel(12'h150, 64'h2F);
      access(12'h151, 0, '0, 2'd1, 0, "R6");

      // R7/R8 guest view of the supervisor window
      wsel(12'h250, 64'h200); access(12'h151, 0, '0, 2'd1, 1, "R7");
      wsel(12'h250, 64'h35);  access(12'h151, 0, '0, 2'd1, 1, "R7");
      wsel(12'h250, 64'h81);  access(12'h151, 0, '0, 2'd1, 1, "R7");
      wsel(12'h250, 64'h82);  access(12'h151, 0, '0, 2'd1, 1, "R7");
      wsel(12'h250, 64'h1FF); access(12'h151, 0, '0, 2'd1, 1, "R7");
      access(12'h151, 0, '0, 2'd0, 1, "R8");
      access(12'h151, 0, '0, 2'd3, 1, "R13");

      // R9 guest window
      wsel(12'h250, 64'h70); access(12'h251, 0, '0, 2'd3, 0, "R9");
      wsel(12'h250, 64'h6F); access(12'h251, 0, '0, 2'd1, 0, "R9");
      access(12'h251, 0, '0, 2'd1, 1, "R9");
      access(12'h251, 0, '0, 2'd0, 1, "R9");

      // R10 trap bit
      wsel(12'h609, 64'h4000_0000);
      access(12'h144, 0, '0, 2'd1, 1, "R10");
      access(12'h104, 0, '0, 2'd1, 1, "R10");
      access(12'h104, 0, '0, 2'd1, 0, "R10");
      wsel(12'h609, 64'h0);
      access(12'h144, 0, '0, 2'd1, 1, "R10");

      // R11 top registers: writes accepted, no state touched
      wsel(12'h350, 64'hAB); wsel(12'h150, 64'hCD);
      access(12'hFB0, 1, 64'hFFFF_FFFF, 2'd3, 0, "R11");
      access(12'hDB0, 1, 64'hFFFF_FFFF, 2'd1, 0, "R11");
      access(12'hEB0, 1, 64'hFFFF_FFFF, 2'd1, 1, "R11");
      access(12'h350, 0, '0, 2'd3, 0, "R11");
      access(12'h150, 0, '0, 2'd3, 0, "R11");
      access(12'h308, 0, '0, 2'd3, 0, "R11");

      // constrained random mix
      for (int i = 0; i < 800; i++) begin
         logic [11:0] a;
         logic [1:0] p;
         logic v, w;
         logic [XLEN-1:0] d;
         a = ($urandom % 10 == 0) ? 12'($urandom) : alist[$urandom % 14];
         case ($urandom % 3)
            0: p = 2'd0;
            1: p = 2'd1;
            default: p = 2'd3;
         endcase
         v = 1'($urandom);
         w = ($urandom % 3 == 0);
         d = {32'($urandom), 32'($urandom)};
         if ($urandom % 4 != 0) d[11:0] = 12'($urandom % 12'h280);
         access(a, w, d, p, v, tag_of(a));
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule